// File: doc/BRIEF.md
# Pattern Table Lookup Unit

This unit carries out a table-driven pattern instruction. When started it forms a table address from an instruction immediate and two 4-bit accumulator values, A and B. It reads one 10-bit word from an internal lookup ROM whose contents are set by a parameter. The top two bits of that word steer its low byte. One bit sends the byte back into the A/B register pair. The other drives it onto a low and a high 4-bit output port. Either bit, both bits or neither may be set.

An alternate addressing mode is chosen per operation. In that mode the address is built from A, B, a carry bit, three opcode bits and the upper program-counter bits. The routed data is also bit-reversed: the nibble for A is mirrored, and the byte for the ports is mirrored as a whole before it is split. Every address is cut to the ROM's own width before the read. A start that arrives while an operation is still running is dropped.

Top module: `pat_lookup_unit`

## Requirements
- R1: During and directly after reset, busy_o, done_o, lo_we_o and hi_we_o are 0, and a_o, b_o, lo_dat_o and hi_dat_o are 0.
- R2: In normal mode (alt_mode_i = 0) the table address is {imm_i, b_i, a_i}, with A in bits 3:0, B in bits 7:4 and the immediate above them. Only its low ROM_AW bits are used.
- R3: In alternate mode (alt_mode_i = 1) the table address is {pc_hi_i, imm_i[2:0], carry_i, b_i, a_i}: A in bits 3:0, B in bits 7:4, carry in bit 8, opcode bits in 11:9 and PC bits above. Only its low ROM_AW bits are used.
- R4: When bit 8 of the word is 1 in normal mode, a_o takes word bits 3:0 and b_o takes word bits 7:4. When bit 8 is 0, a_o and b_o keep their previous values.
- R5: When bit 9 of the word is 1 in normal mode, lo_dat_o takes word bits 3:0 and hi_dat_o takes word bits 7:4. lo_we_o and hi_we_o are each high for exactly the one cycle in which done_o is high.
- R6: Bits 8 and 9 act independently. With both set, the registers and the ports update in the same operation. With neither set, no port strobe is raised and no output value changes.
- R7: In alternate mode, a_o takes the bit-reversal of word bits 3:0 (new bit k = old bit 3-k) and b_o takes word bits 7:4. The ports take the 8-bit reversal of word bits 7:0, with its bits 3:0 on lo_dat_o and bits 7:4 on hi_dat_o.
- R8: The operation takes one extra cycle for the table read. With start accepted at clock edge 0, the ROM is read at edge 1, and the results and done_o appear after edge 2.
- R9: done_o is high for exactly one cycle per operation. A start_i pulse while busy_o is high is ignored and starts no operation.
- R10: busy_o is high from the edge that accepts start until the edge at which done_o rises, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, sampled when idle |
| imm_i | input | IMM_W | Instruction immediate / opcode bits |
| a_i | input | 4 | Current A accumulator value |
| b_i | input | 4 | Current B accumulator value |
| alt_mode_i | input | 1 | Selects the alternate address and bit-reversed routing |
| carry_i | input | 1 | Carry bit used in alternate addressing |
| pc_hi_i | input | PC_W | Upper program-counter bits used in alternate addressing |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| a_o | output | 4 | Updated A value |
| b_o | output | 4 | Updated B value |
| lo_we_o | output | 1 | Low port write strobe |
| lo_dat_o | output | 4 | Low port data |
| hi_we_o | output | 1 | High port write strobe |
| hi_dat_o | output | 4 | High port data |

## Verification
The bench builds the unit with IMM_W = 3, PC_W = 4 and ROM_AW = 10, and fills the 1024-entry table from an arithmetic formula that the bench evaluates again on its own. With these sizes, every A, B and immediate combination can be swept in both modes. The top immediate bit in normal mode, and the upper opcode and PC bits in alternate mode, fall outside the ROM width, so the masking is exercised on every sweep. The formula gives every combination of the two steering bits many times over, which covers both destinations, each alone, and the no-op case. A separate case drives start during the busy window.

// File: rtl/pat_pkg.sv
package pat_pkg;

    localparam int NIB_W  = 4;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 10;
    localparam int OPC_W  = 3;

    typedef logic [NIB_W-1:0] nib_t;

    typedef struct packed {
        logic              to_ports;
        logic              to_regs;
        logic [BYTE_W-1:0] data;
    } pword_s;

    typedef enum logic [1:0] {
        PS_IDLE  = 2'd0,
        PS_FETCH = 2'd1,
        PS_WRITE = 2'd2
    } pstate_e;

    function automatic nib_t rev4(input nib_t v);
        nib_t r;
        for (int k = 0; k < NIB_W; k++) r[k] = v[NIB_W-1-k];
        return r;
    endfunction

    function automatic logic [BYTE_W-1:0] rev8(input logic [BYTE_W-1:0] v);
        logic [BYTE_W-1:0] r;
        for (int k = 0; k < BYTE_W; k++) r[k] = v[BYTE_W-1-k];
        return r;
    endfunction

endpackage

// File: rtl/pat_addr_gen.sv
module pat_addr_gen
    import pat_pkg::*;
#(
    parameter int IMM_W  = 3,
    parameter int PC_W   = 4,
    parameter int ROM_AW = 10
) (
    input  logic              alt,
    input  logic [IMM_W-1:0]  imm,
    input  nib_t              a,
    input  nib_t              b,
    input  logic              carry,
    input  logic [PC_W-1:0]   pc_hi,
    output logic [ROM_AW-1:0] addr
);
    localparam int NRM_W = IMM_W + 2*NIB_W;
    localparam int ALT_W = PC_W + OPC_W + 1 + 2*NIB_W;
    localparam int MX_W  = (NRM_W > ALT_W) ? NRM_W : ALT_W;
    localparam int LW    = (MX_W > ROM_AW) ? MX_W : ROM_AW;

    logic [OPC_W-1:0] opc;
    logic [LW-1:0]    norm_l, alt_l, sel_l;

    generate
        if (IMM_W >= OPC_W) begin : g_opc_wide
            assign opc = imm[OPC_W-1:0];
        end else begin : g_opc_narrow
            assign opc = {{(OPC_W-IMM_W){1'b0}}, imm};
        end
    endgenerate

    always_comb begin
        norm_l = LW'({imm, b, a});
        alt_l  = LW'({pc_hi, opc, carry, b, a});
        sel_l  = alt ? alt_l : norm_l;
        addr   = sel_l[ROM_AW-1:0];
    end

endmodule

// File: rtl/pat_rom.sv
module pat_rom
    import pat_pkg::*;
#(
    parameter int ROM_AW = 10,
    parameter logic [WORD_W*(1<<ROM_AW)-1:0] IMAGE = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [ROM_AW-1:0] addr,
    output pword_s            rdata
);
    localparam int DEPTH = 1 << ROM_AW;

    logic [WORD_W-1:0] table_w [DEPTH];

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_word
            assign table_w[i] = IMAGE[i*WORD_W +: WORD_W];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)        rdata <= '0;
        else if (rd_en) rdata <= pword_s'(table_w[addr]);
    end

endmodule

// File: rtl/pat_route.sv
module pat_route
    import pat_pkg::*;
(
    input  logic   alt,
    input  pword_s word,
    output nib_t   a_nxt,
    output nib_t   b_nxt,
    output nib_t   lo_nxt,
    output nib_t   hi_nxt,
    output logic   ld_regs,
    output logic   ld_ports
);
    logic [BYTE_W-1:0] port_byte;

    always_comb begin
        ld_regs   = word.to_regs;
        ld_ports  = word.to_ports;
        a_nxt     = alt ? rev4(word.data[3:0]) : word.data[3:0];
        b_nxt     = word.data[7:4];
        port_byte = alt ? rev8(word.data) : word.data;
        lo_nxt    = port_byte[3:0];
        hi_nxt    = port_byte[7:4];
    end

endmodule

// File: rtl/pat_lookup_unit.sv
module pat_lookup_unit
    import pat_pkg::*;
#(
    parameter int IMM_W  = 3,
    parameter int PC_W   = 4,
    parameter int ROM_AW = 10,
    parameter logic [WORD_W*(1<<ROM_AW)-1:0] IMAGE = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic [3:0]       a_i,
    input  logic [3:0]       b_i,
    input  logic             alt_mode_i,
    input  logic             carry_i,
    input  logic [PC_W-1:0]  pc_hi_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [3:0]       a_o,
    output logic [3:0]       b_o,
    output logic             lo_we_o,
    output logic [3:0]       lo_dat_o,
    output logic             hi_we_o,
    output logic [3:0]       hi_dat_o
);
    pstate_e           state;
    logic [ROM_AW-1:0] addr_w, addr_q;
    logic              alt_q;
    pword_s            word_q;
    nib_t              a_nxt, b_nxt, lo_nxt, hi_nxt;
    logic              ld_regs, ld_ports;

    pat_addr_gen #(.IMM_W(IMM_W), .PC_W(PC_W), .ROM_AW(ROM_AW)) u_addr (
        .alt(alt_mode_i), .imm(imm_i), .a(a_i), .b(b_i),
        .carry(carry_i), .pc_hi(pc_hi_i), .addr(addr_w)
    );

    pat_rom #(.ROM_AW(ROM_AW), .IMAGE(IMAGE)) u_rom (
        .clk(clk), .rst(rst), .rd_en(state == PS_FETCH),
        .addr(addr_q), .rdata(word_q)
    );

    pat_route u_route (
        .alt(alt_q), .word(word_q),
        .a_nxt(a_nxt), .b_nxt(b_nxt), .lo_nxt(lo_nxt), .hi_nxt(hi_nxt),
        .ld_regs(ld_regs), .ld_ports(ld_ports)
    );

    assign busy_o = (state != PS_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= PS_IDLE;
            addr_q   <= '0;
            alt_q    <= 1'b0;
            done_o   <= 1'b0;
            a_o      <= '0;
            b_o      <= '0;
            lo_we_o  <= 1'b0;
            hi_we_o  <= 1'b0;
            lo_dat_o <= '0;
            hi_dat_o <= '0;
        end else begin
            done_o  <= 1'b0;
            lo_we_o <= 1'b0;
            hi_we_o <= 1'b0;
            case (state)
                PS_IDLE: begin
                    if (start_i) begin
                        addr_q <= addr_w;
                        alt_q  <= alt_mode_i;
                        state  <= PS_FETCH;
                    end
                end
                PS_FETCH: state <= PS_WRITE;
                PS_WRITE: begin
                    done_o <= 1'b1;
                    if (ld_regs) begin
                        a_o <= a_nxt;
                        b_o <= b_nxt;
                    end
                    if (ld_ports) begin
                        lo_we_o  <= 1'b1;
                        hi_we_o  <= 1'b1;
                        lo_dat_o <= lo_nxt;
                        hi_dat_o <= hi_nxt;
                    end
                    state <= PS_IDLE;
                end
                default: state <= PS_IDLE;
            endcase
        end
    end

    // R9
    done_one_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R9
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i) |=> (state != PS_FETCH));

    // R8
    fetch_adv_chk: assert property (@(posedge clk) disable iff (rst)
        (state == PS_FETCH) |=> (state == PS_WRITE && busy_o));

    // R4
    a_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> ($stable(a_o) && $stable(b_o)));

    // R5
    port_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (lo_we_o || hi_we_o) |-> done_o);

    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

endmodule

// File: tb/sim_pat_lookup_unit.sv
module sim_pat_lookup_unit;
    localparam int IMM_W = 3;
    localparam int PC_W  = 4;
    localparam int AW    = 10;
    localparam int DEPTH = 1 << AW;

    function automatic logic [9:0] wf(input int i);
        return 10'((i * 157 + 71) ^ (i >> 3));
    endfunction

    function automatic logic [10*DEPTH-1:0] build();
        logic [10*DEPTH-1:0] v;
        for (int i = 0; i < DEPTH; i++) v[i*10 +: 10] = wf(i);
        return v;
    endfunction

    localparam logic [10*DEPTH-1:0] IMG = build();

    logic clk = 1'b0, rst = 1'b1, start = 1'b0, alt = 1'b0, carry = 1'b0;
    logic [IMM_W-1:0] imm = '0;
    logic [3:0] a_in = '0, b_in = '0;
    logic [PC_W-1:0] pc = '0;
    logic busy, done, lo_we, hi_we;
    logic [3:0] a_o, b_o, lo_d, hi_d;

    int checks = 0, errors = 0;
    logic [3:0] ea = '0, eb = '0, elo = '0, ehi = '0;
    bit finished = 0;

    always #10 clk = ~clk;

    pat_lookup_unit #(.IMM_W(IMM_W), .PC_W(PC_W), .ROM_AW(AW), .IMAGE(IMG)) u0 (
        .clk(clk), .rst(rst), .start_i(start), .imm_i(imm), .a_i(a_in), .b_i(b_in),
        .alt_mode_i(alt), .carry_i(carry), .pc_hi_i(pc),
        .busy_o(busy), .done_o(done), .a_o(a_o), .b_o(b_o),
        .lo_we_o(lo_we), .lo_dat_o(lo_d), .hi_we_o(hi_we), .hi_dat_o(hi_d)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] r4(input logic [3:0] v);
        return {v[0], v[1], v[2], v[3]};
    endfunction

    task automatic run_op(input logic m, input logic [2:0] im, input logic [3:0] av,
                          input logic [3:0] bv, input logic c, input logic [3:0] p,
                          input bit spurious);
        int ad;
        logic [9:0] w;
        logic [7:0] pb;
        bit wexp;
        @(negedge clk);
        alt = m; imm = im; a_in = av; b_in = bv; carry = c; pc = p; start = 1'b1;
        // R2 / R3: address formed independently and masked to AW bits
        if (m) ad = int'({p, im, c, bv, av}) % DEPTH;
        else   ad = int'({im, bv, av}) % DEPTH;
        w = wf(ad);
        @(negedge clk);
        start = spurious;
        if (spurious) begin imm = ~im; a_in = ~av; alt = ~m; end
        chk(busy == 1'b1, "R10 busy after accept", busy, 1);
        chk(done == 1'b0, "R8 no early done", done, 0);
        @(negedge clk);
        chk(busy == 1'b1 && done == 1'b0, "R8 read cycle", {busy, done}, 2);
        @(negedge clk);
        start = 1'b0;
        if (w[8]) begin
            ea = m ? r4(w[3:0]) : w[3:0];
            eb = w[7:4];
        end
        wexp = w[9];
        if (w[9]) begin
            pb  = m ? {w[0], w[1], w[2], w[3], w[4], w[5], w[6], w[7]} : w[7:0];
            elo = pb[3:0];
            ehi = pb[7:4];
        end
        chk(done == 1'b1 && busy == 1'b0, "R8 done after two cycles", {busy, done}, 1);
        chk(a_o == ea, m ? "R7 a_o" : (w[8] ? "R4 a_o" : "R6 a_o held"), a_o, ea);
        chk(b_o == eb, m ? "R7 b_o" : "R4 b_o", b_o, eb);
        chk(lo_we == wexp && hi_we == wexp, "R5 port strobes", {lo_we, hi_we}, {wexp, wexp});
        chk(lo_d == elo, m ? "R7 lo port" : "R5 lo port", lo_d, elo);
        chk(hi_d == ehi, m ? "R7 hi port" : "R5 hi port", hi_d, ehi);
        @(negedge clk);
        chk(done == 1'b0 && lo_we == 1'b0 && hi_we == 1'b0, "R9 one-cycle done",
            {done, lo_we, hi_we}, 0);
        chk(busy == 1'b0, spurious ? "R9 busy start ignored" : "R10 idle", busy, 0);
        if (spurious) begin
            @(negedge clk);
            chk(busy == 1'b0 && a_o == ea && lo_d == elo, "R9 no second op",
                {busy, a_o, lo_d}, {1'b0, ea, elo});
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(busy == 0 && done == 0 && lo_we == 0 && hi_we == 0, "R1 reset flags",
            {busy, done, lo_we, hi_we}, 0);
        chk(a_o == 0 && b_o == 0 && lo_d == 0 && hi_d == 0, "R1 reset data",
            {a_o, b_o, lo_d, hi_d}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 0 && done == 0 && a_o == 0, "R1 after reset", {busy, done, a_o}, 0);
        // R2 R4 R5 R6: normal-mode sweep
        for (int i = 0; i < 8; i++)
            for (int b = 0; b < 16; b++)
                for (int a = 0; a < 16; a++)
                    run_op(1'b0, 3'(i), 4'(a), 4'(b), 1'(a ^ b), 4'(i + b), 0);
        // R3 R7: alternate-mode sweep
        for (int c = 0; c < 2; c++)
            for (int i = 0; i < 8; i++)
                for (int b = 0; b < 16; b++)
                    for (int a = 0; a < 16; a++)
                        run_op(1'b1, 3'(i), 4'(a), 4'(b), 1'(c), 4'(a + 3 * b), 0);
        // R9: start during busy
        for (int k = 0; k < 8; k++)
            run_op(1'(k & 1), 3'(k), 4'(k * 5), 4'(k * 3), 1'(k >> 1), 4'(k), 1);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule